// File: doc/BRIEF.md
# Command Response Packet Formatter

This block sits behind a host command parser. Each cycle it may take one decoded request: a packet type byte, a command byte, a request length, four argument bytes, and for device-bus requests the result of the bus transaction (a signed status byte and up to four reply bytes). It builds the matching response frame and streams it back one byte at a time over a valid/ready byte interface. A last flag marks the final byte of each frame.

Three response layouts cover every supported command. The first is a 3-byte acknowledge that echoes the command. The second is a 4-byte error frame carrying an error code. The third is an acknowledge extended with a big-endian 32-bit time value. The block keeps that time value itself. A set-time command loads it, a seconds tick advances it, and a get-time command reads it back. Power-down and system-reset commands also raise a one-cycle request pulse for the rest of the chip.

Top module: `rsp_formatter`

## Requirements
- R1: After reset, `rsp_valid`, `busy`, `pwr_down_req` and `sys_reset_req` are 0, `req_ready` is 1, and the stored time is 0.
- R2: A command-type request (`req_ptype == PT_CMD`) whose command is autopoll (0x01), device-list (0x19), auto-rate (0x14) or power-message (0x21) answers with exactly 3 bytes, in this order: `PT_CMD`, 0x00, the echoed command.
- R3: Set-time (0x09) loads the stored time from the four argument bytes, with `req_args[31:24]` as the most significant byte, and answers with the 3-byte acknowledge.
- R4: Get-time (0x03) answers with 7 bytes. The first three are the acknowledge bytes. The last four are the stored time at the accepting edge, most significant byte first.
- R5: Each cycle with `sec_tick` high adds 1 to the stored time, modulo 2^32. A set-time accepted in the same cycle overrides the tick.
- R6: Combined-format bus command (0x25) always answers with 4 bytes, in this order: `PT_ERR`, 0x05, `PT_CMD`, the echoed command.
- R7: Get/set bus command (0x22) with `req_len == 4` answers with the 3-byte acknowledge. Any other length answers with `PT_ERR`, 0x02, `PT_CMD`, the echoed command.
- R8: A device request (`req_ptype == PT_DEV`) whose `req_dev_status` is zero or negative (two's complement) answers with `PT_DEV`, the negated status, and `req_args[31:24]`. A positive status n answers with `PT_DEV`, 0x00, then the first min(n, MAX_REPLY) bytes of `req_dev_reply`, taken from bits 31:24 downward.
- R9: Power-down (0x0A) and system-reset (0x11) answer with the 3-byte acknowledge. They also drive `pwr_down_req` or `sys_reset_req`, respectively, high for exactly the one cycle that follows the accepting edge.
- R10: An unknown command, or an unknown packet type, produces no response bytes and no request pulse, and `req_ready` stays high.
- R11: A request is accepted only while `req_ready` is high. `req_ready` is low and `busy` is high from the cycle after a response-producing request is accepted until the last byte has been accepted. `rsp_data` and `rsp_last` hold while `rsp_valid` is high and `rsp_ready` is low, and `rsp_last` is high only on the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_ptype | input | 8 | Request packet type |
| req_cmd | input | 8 | Command byte |
| req_len | input | 4 | Request length in bytes |
| req_args | input | 32 | Argument bytes, first in bits 31:24 |
| req_dev_status | input | 8 | Device transaction result, signed |
| req_dev_reply | input | 32 | Device reply bytes, first in bits 31:24 |
| sec_tick | input | 1 | One-second tick |
| rsp_valid | output | 1 | Response byte present |
| rsp_ready | input | 1 | Receiver takes the byte |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the frame |
| busy | output | 1 | A response frame is in flight |
| pwr_down_req | output | 1 | Power-down request pulse |
| sys_reset_req | output | 1 | System-reset request pulse |

## Verification
The bench builds the block with packet type codes 0x40, 0x41 and 0x42 rather than the defaults. With those values a type byte can never be confused with the zero status byte or with a small echoed command. It sets MAX_REPLY to 3. That lets a device status of 6 reach the clamp on reply length while a status of 2 stays below it. A receiver that stalls every third cycle brings the hold rule on the response bytes within reach. A set-time loaded with 0xFFFFFFFF, followed by one tick, exercises wraparound of the stored time.

// File: rtl/rspfmt_pkg.sv
package rspfmt_pkg;

    localparam int FRAME_MAX = 7;
    localparam int IDX_W     = $clog2(FRAME_MAX + 1);
    localparam int TIME_W    = 32;

    typedef logic [7:0] byte_t;

    localparam byte_t CMD_AUTOPOLL   = 8'h01;
    localparam byte_t CMD_GET_TIME   = 8'h03;
    localparam byte_t CMD_SET_TIME   = 8'h09;
    localparam byte_t CMD_POWER_OFF  = 8'h0A;
    localparam byte_t CMD_SYS_RESET  = 8'h11;
    localparam byte_t CMD_AUTO_RATE  = 8'h14;
    localparam byte_t CMD_DEV_LIST   = 8'h19;
    localparam byte_t CMD_PWR_MSG    = 8'h21;
    localparam byte_t CMD_BUS_GETSET = 8'h22;
    localparam byte_t CMD_BUS_COMBO  = 8'h25;

    localparam byte_t ERR_BUS_COMBO  = 8'h05;
    localparam byte_t ERR_BUS_LEN    = 8'h02;

    typedef enum logic [2:0] {
        K_NONE, K_ACK, K_SET_TIME, K_GET_TIME,
        K_BUS_COMBO, K_BUS_GETSET, K_PWR_OFF, K_SYS_RST
    } cmd_kind_t;

    typedef struct packed {
        byte_t        ptype;
        byte_t        cmd;
        logic [3:0]   len;
        logic [31:0]  args;
        byte_t        dev_status;
        logic [31:0]  dev_reply;
    } request_t;

    typedef struct packed {
        logic                        valid;
        logic [IDX_W-1:0]            len;
        logic [FRAME_MAX-1:0][7:0]   bytes;
        logic                        store_time;
        logic                        pwr_off;
        logic                        sys_rst;
    } frame_t;

    function automatic cmd_kind_t classify(input byte_t cmd);
        case (cmd)
            CMD_AUTOPOLL, CMD_DEV_LIST,
            CMD_AUTO_RATE, CMD_PWR_MSG: return K_ACK;
            CMD_SET_TIME:               return K_SET_TIME;
            CMD_GET_TIME:               return K_GET_TIME;
            CMD_BUS_COMBO:              return K_BUS_COMBO;
            CMD_BUS_GETSET:             return K_BUS_GETSET;
            CMD_POWER_OFF:              return K_PWR_OFF;
            CMD_SYS_RESET:              return K_SYS_RST;
            default:                    return K_NONE;
        endcase
    endfunction

    function automatic byte_t word_byte(input logic [31:0] w, input int i);
        return w[31-8*i -: 8];
    endfunction

endpackage

// File: rtl/rsp_timekeeper.sv
module rsp_timekeeper
    import rspfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst)       now <= '0;
        else if (load) now <= load_val;
        else if (tick) now <= now + TIME_W'(1);
    end

    // R5: a tick without a load advances the time by exactly one
    assert_tick_step_R5: assert property (@(posedge clk) disable iff (rst)
        tick && !load |=> now == $past(now) + TIME_W'(1));

    // R3: a load wins over a tick in the same cycle
    assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> now == $past(load_val));

endmodule

// File: rtl/rsp_decode.sv
module rsp_decode
    import rspfmt_pkg::*;
#(
    parameter logic [7:0] PT_DEV    = 8'h00,
    parameter logic [7:0] PT_CMD    = 8'h01,
    parameter logic [7:0] PT_ERR    = 8'h02,
    parameter int         MAX_REPLY = 4
)(
    input  request_t          req,
    input  logic [TIME_W-1:0] now,
    output frame_t            frame
);

    localparam int HDR = 2;

    cmd_kind_t        kind;
    logic [IDX_W-1:0] n_rep;
    logic             dev_fail;

    assign kind     = classify(req.cmd);
    assign dev_fail = req.dev_status[7] || (req.dev_status == 8'h00);

    always_comb begin
        if (req.dev_status > 8'(MAX_REPLY)) n_rep = IDX_W'(MAX_REPLY);
        else                                n_rep = req.dev_status[IDX_W-1:0];
    end

    always_comb begin
        frame = '0;
        if (req.ptype == PT_DEV) begin
            frame.valid    = 1'b1;
            frame.bytes[0] = PT_DEV;
            if (dev_fail) begin
                frame.bytes[1] = 8'(~req.dev_status + 8'd1);
                frame.bytes[2] = word_byte(req.args, 0);
                frame.len      = IDX_W'(3);
            end else begin
                frame.bytes[1] = 8'h00;
                for (int i = 0; i < MAX_REPLY; i++) begin
                    if (IDX_W'(i) < n_rep)
                        frame.bytes[HDR+i] = word_byte(req.dev_reply, i);
                end
                frame.len = IDX_W'(HDR) + n_rep;
            end
        end else if (req.ptype == PT_CMD) begin
            frame.bytes[0] = PT_CMD;
            frame.bytes[1] = 8'h00;
            frame.bytes[2] = req.cmd;
            frame.len      = IDX_W'(3);
            frame.valid    = (kind != K_NONE);
            case (kind)
                K_SET_TIME: frame.store_time = 1'b1;
                K_GET_TIME: begin
                    for (int i = 0; i < 4; i++)
                        frame.bytes[3+i] = word_byte(now, i);
                    frame.len = IDX_W'(7);
                end
                K_BUS_COMBO: begin
                    frame.bytes = '0;
                    frame.bytes[0] = PT_ERR;
                    frame.bytes[1] = ERR_BUS_COMBO;
                    frame.bytes[2] = PT_CMD;
                    frame.bytes[3] = req.cmd;
                    frame.len      = IDX_W'(4);
                end
                K_BUS_GETSET: begin
                    if (req.len != 4'd4) begin
                        frame.bytes = '0;
                        frame.bytes[0] = PT_ERR;
                        frame.bytes[1] = ERR_BUS_LEN;
                        frame.bytes[2] = PT_CMD;
                        frame.bytes[3] = req.cmd;
                        frame.len      = IDX_W'(4);
                    end
                end
                K_PWR_OFF: frame.pwr_off = 1'b1;
                K_SYS_RST: frame.sys_rst = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rsp_serializer.sv
module rsp_serializer
    import rspfmt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame_in,
    input  logic   rsp_ready,
    output logic   rsp_valid,
    output logic [7:0] rsp_data,
    output logic   rsp_last
);

    logic [FRAME_MAX-1:0][7:0] bytes_q;
    logic [IDX_W-1:0]          len_q;
    logic [IDX_W-1:0]          idx_q;
    logic                      active_q;

    assign rsp_valid = active_q;
    assign rsp_data  = bytes_q[idx_q];
    assign rsp_last  = active_q && (idx_q == len_q - IDX_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q  <= '0;
            len_q    <= '0;
            idx_q    <= '0;
            active_q <= 1'b0;
        end else if (!active_q) begin
            if (load) begin
                bytes_q  <= frame_in.bytes;
                len_q    <= frame_in.len;
                idx_q    <= '0;
                active_q <= 1'b1;
            end
        end else if (rsp_ready) begin
            if (rsp_last) active_q <= 1'b0;
            else          idx_q    <= idx_q + IDX_W'(1);
        end
    end

    // R11: a stalled byte is held unchanged
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_last));

    // R11: the frame ends once its last byte is taken
    assert_frame_end_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready && rsp_last |=> !rsp_valid);

endmodule

// File: rtl/rsp_formatter.sv
module rsp_formatter
    import rspfmt_pkg::*;
#(
    parameter logic [7:0] PT_DEV    = 8'h00,
    parameter logic [7:0] PT_CMD    = 8'h01,
    parameter logic [7:0] PT_ERR    = 8'h02,
    parameter int         MAX_REPLY = 4
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [7:0]  req_ptype,
    input  logic [7:0]  req_cmd,
    input  logic [3:0]  req_len,
    input  logic [31:0] req_args,
    input  logic [7:0]  req_dev_status,
    input  logic [31:0] req_dev_reply,
    input  logic        sec_tick,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [7:0]  rsp_data,
    output logic        rsp_last,
    output logic        busy,
    output logic        pwr_down_req,
    output logic        sys_reset_req
);

    request_t          req;
    frame_t            frame;
    logic [TIME_W-1:0] now;
    logic              accept;

    assign req = '{ptype: req_ptype, cmd: req_cmd, len: req_len, args: req_args,
                   dev_status: req_dev_status, dev_reply: req_dev_reply};

    assign busy      = rsp_valid;
    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    rsp_decode #(.PT_DEV(PT_DEV), .PT_CMD(PT_CMD), .PT_ERR(PT_ERR),
                 .MAX_REPLY(MAX_REPLY)) decode_i (
        .req   (req),
        .now   (now),
        .frame (frame)
    );

    rsp_timekeeper time_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .load     (accept && frame.store_time),
        .load_val (req_args),
        .now      (now)
    );

    rsp_serializer ser_i (
        .clk       (clk),
        .rst       (rst),
        .load      (accept && frame.valid),
        .frame_in  (frame),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_down_req  <= 1'b0;
            sys_reset_req <= 1'b0;
        end else begin
            pwr_down_req  <= accept && frame.pwr_off;
            sys_reset_req <= accept && frame.sys_rst;
        end
    end

    // R9: a request pulse coincides with its acknowledge frame
    assert_pulse_with_ack_R9: assert property (@(posedge clk) disable iff (rst)
        pwr_down_req || sys_reset_req |-> rsp_valid);

    // R9: the two request pulses never overlap
    assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(pwr_down_req && sys_reset_req));

    // R10: an unrecognised request leaves the output idle
    assert_silent_R10: assert property (@(posedge clk) disable iff (rst)
        accept && !frame.valid |=> !rsp_valid && req_ready);

endmodule

// File: tb/rsp_formatter_tb_top.sv
module rsp_formatter_tb_top;

    localparam logic [7:0] T_DEV = 8'h40;
    localparam logic [7:0] T_CMD = 8'h41;
    localparam logic [7:0] T_ERR = 8'h42;
    localparam int         NREP  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [7:0]  req_ptype = '0;
    logic [7:0]  req_cmd = '0;
    logic [3:0]  req_len = '0;
    logic [31:0] req_args = '0;
    logic [7:0]  req_dev_status = '0;
    logic [31:0] req_dev_reply = '0;
    logic sec_tick = 1'b0;
    logic rsp_valid;
    logic rsp_ready = 1'b1;
    logic [7:0] rsp_data;
    logic rsp_last;
    logic busy, pwr_down_req, sys_reset_req;

    always #10 clk = ~clk;

    rsp_formatter #(.PT_DEV(T_DEV), .PT_CMD(T_CMD), .PT_ERR(T_ERR),
                    .MAX_REPLY(NREP)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ptype(req_ptype), .req_cmd(req_cmd), .req_len(req_len),
        .req_args(req_args), .req_dev_status(req_dev_status),
        .req_dev_reply(req_dev_reply), .sec_tick(sec_tick),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .busy(busy), .pwr_down_req(pwr_down_req),
        .sys_reset_req(sys_reset_req)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit stall = 1'b0;
    string cur_tag = "R1";
    logic [8:0] expq[$];
    logic [31:0] tm = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    // response monitor, compared each clock against the reference queue
    always begin
        @(negedge clk);
        rsp_ready = stall ? (cyc % 3 != 1) : 1'b1;
        #1;
        if (!rst && rsp_valid && rsp_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, {cur_tag, " unexpected byte"}, {24'd0, rsp_data}, 32'hx);
            end else begin
                logic [8:0] e;
                e = expq.pop_front();
                chk(rsp_data == e[7:0], {cur_tag, " data"}, {24'd0, rsp_data}, {24'd0, e[7:0]});
                chk(rsp_last == e[8], "R11 last", {31'd0, rsp_last}, {31'd0, e[8]});
            end
        end
    end

    task automatic send(input logic [7:0] pt, input logic [7:0] cmd,
                        input logic [3:0] ln, input logic [31:0] a,
                        input logic [7:0] ds, input logic [31:0] dr,
                        input bit tk, input string tag);
        logic [7:0] b[$];
        bit pw, rs;
        int n;
        b = {};
        pw = 1'b0;
        rs = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_tag = tag;
        req_ptype = pt; req_cmd = cmd; req_len = ln; req_args = a;
        req_dev_status = ds; req_dev_reply = dr;
        req_valid = 1'b1;
        sec_tick = tk;
        @(posedge clk);
        if (pt == T_DEV) begin
            if (ds[7] || ds == 8'h00) begin
                b = {T_DEV, 8'(-ds), a[31:24]};
            end else begin
                n = (ds > NREP) ? NREP : int'(ds);
                b = {T_DEV, 8'h00};
                for (int i = 0; i < n; i++) b.push_back(dr[31-8*i -: 8]);
            end
        end else if (pt == T_CMD) begin
            case (cmd)
                8'h01, 8'h19, 8'h14, 8'h21, 8'h09: b = {T_CMD, 8'h00, cmd};
                8'h0A: begin b = {T_CMD, 8'h00, cmd}; pw = 1'b1; end
                8'h11: begin b = {T_CMD, 8'h00, cmd}; rs = 1'b1; end
                8'h03: b = {T_CMD, 8'h00, cmd, tm[31:24], tm[23:16], tm[15:8], tm[7:0]};
                8'h25: b = {T_ERR, 8'h05, T_CMD, cmd};
                8'h22: if (ln == 4) b = {T_CMD, 8'h00, cmd};
                       else         b = {T_ERR, 8'h02, T_CMD, cmd};
                default: b = {};
            endcase
        end
        if (pt == T_CMD && cmd == 8'h09) tm = a;
        else if (tk)                     tm = tm + 32'd1;
        for (int i = 0; i < b.size(); i++)
            expq.push_back({(i == b.size() - 1), b[i]});
        #1;
        req_valid = 1'b0;
        sec_tick = 1'b0;
        @(negedge clk); #2;
        chk(pwr_down_req == pw, "R9 power pulse", {31'd0, pwr_down_req}, {31'd0, pw});
        chk(sys_reset_req == rs, "R9 reset pulse", {31'd0, sys_reset_req}, {31'd0, rs});
        chk(req_ready == (b.size() == 0), b.size() == 0 ? "R10 ready" : "R11 ready",
            {31'd0, req_ready}, {31'd0, (b.size() == 0)});
        @(negedge clk); #2;
        chk(!pwr_down_req && !sys_reset_req, "R9 pulse width",
            {30'd0, pwr_down_req, sys_reset_req}, 32'd0);
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk); #2;
        chk(!rsp_valid && req_ready && !busy, "R11 idle after frame",
            {29'd0, rsp_valid, req_ready, busy}, 32'd2);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(posedge clk);
        tm = tm + 32'd1;
        #1 sec_tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(!rsp_valid && req_ready && !busy && !pwr_down_req && !sys_reset_req,
            "R1 reset outputs",
            {27'd0, rsp_valid, req_ready, busy, pwr_down_req, sys_reset_req}, 32'h8);
        rst = 1'b0;
        // R1: stored time starts at zero
        send(T_CMD, 8'h03, 4'd1, 32'h0, 8'h0, 32'h0, 1'b0, "R1");
        // R2
        send(T_CMD, 8'h01, 4'd2, 32'h0, 8'h0, 32'h0, 1'b0, "R2");
        send(T_CMD, 8'h19, 4'd2, 32'h0, 8'h0, 32'h0, 1'b0, "R2");
        stall = 1'b1;
        send(T_CMD, 8'h14, 4'd2, 32'h0, 8'h0, 32'h0, 1'b0, "R2");
        send(T_CMD, 8'h21, 4'd2, 32'h0, 8'h0, 32'h0, 1'b0, "R2");
        // R3, R4
        send(T_CMD, 8'h09, 4'd5, 32'h12345678, 8'h0, 32'h0, 1'b0, "R3");
        send(T_CMD, 8'h03, 4'd1, 32'h0, 8'h0, 32'h0, 1'b0, "R4");
        // R5
        repeat (3) pulse_tick();
        send(T_CMD, 8'h03, 4'd1, 32'h0, 8'h0, 32'h0, 1'b0, "R5");
        send(T_CMD, 8'h09, 4'd5, 32'hA0B0C0D0, 8'h0, 32'h0, 1'b1, "R5");
        send(T_CMD, 8'h03, 4'd1, 32'h0, 8'h0, 32'h0, 1'b0, "R5");
        send(T_CMD, 8'h09, 4'd5, 32'hFFFFFFFF, 8'h0, 32'h0, 1'b0, "R3");
        pulse_tick();
        send(T_CMD, 8'h03, 4'd1, 32'h0, 8'h0, 32'h0, 1'b0, "R5");
        stall = 1'b0;
        // R6, R7
        send(T_CMD, 8'h25, 4'd4, 32'h0, 8'h0, 32'h0, 1'b0, "R6");
        send(T_CMD, 8'h22, 4'd4, 32'h0, 8'h0, 32'h0, 1'b0, "R7");
        send(T_CMD, 8'h22, 4'd3, 32'h0, 8'h0, 32'h0, 1'b0, "R7");
        send(T_CMD, 8'h22, 4'd5, 32'h0, 8'h0, 32'h0, 1'b0, "R7");
        // R8
        stall = 1'b1;
        send(T_DEV, 8'h2C, 4'd2, 32'h5A000000, 8'hFD, 32'h0, 1'b0, "R8");
        send(T_DEV, 8'h2C, 4'd2, 32'h77000000, 8'h00, 32'h0, 1'b0, "R8");
        send(T_DEV, 8'h2C, 4'd2, 32'h0, 8'h02, 32'hC1C2C3C4, 1'b0, "R8");
        send(T_DEV, 8'h2C, 4'd2, 32'h0, 8'h06, 32'hD1D2D3D4, 1'b0, "R8");
        stall = 1'b0;
        // R9
        send(T_CMD, 8'h0A, 4'd2, 32'h0, 8'h0, 32'h0, 1'b0, "R9");
        send(T_CMD, 8'h11, 4'd2, 32'h0, 8'h0, 32'h0, 1'b0, "R9");
        // R10
        send(T_CMD, 8'h7E, 4'd2, 32'h0, 8'h0, 32'h0, 1'b0, "R10");
        send(8'h55, 8'h0A, 4'd2, 32'h0, 8'h0, 32'h0, 1'b0, "R10");
        repeat (4) @(negedge clk);
        chk(expq.size() == 0 && !rsp_valid, "R10 no stray output",
            {31'd0, rsp_valid}, 32'd0);
        finish_run();
    end

endmodule